// File: doc/BRIEF.md
# Single-Page Memory Access Grouper

This block sits between a load/store queue and the first level of the data cache. Each cycle it looks at up to two pending loads and one pending store. It picks the oldest of them and admits every other candidate whose virtual page matches. One translation request goes to a single-ported TLB for that page. When the physical page number comes back, the block issues the whole group with physical addresses built from that one result. Candidates for any other page are left waiting and are taken in a later cycle.

Inside an admitted group, loads that fall in the same 64-byte line are merged. Only the lowest-indexed of them raises a bank read enable. Each issued load carries a share tag that names the load slot whose read supplies its data, so a single-ported bank sees at most one read per line.

Requests use a valid/ready handshake. A candidate holds its valid and address until it sees ready in a cycle. While a translation is outstanding no new group is admitted. The exception is the cycle in which the response arrives: a new group can be admitted in that same cycle.

Top module: `mem_access_grouper`

## Requirements
- R1: All requests accepted in one cycle share the same virtual page number, address bits [31:12]; a valid request to another page gets no ready in that cycle.
- R2: When the block can accept, the valid request with the smallest age value is always accepted in that cycle.
- R3: Two loads and one store that target the same page, with no ordering conflict, are all accepted in the same cycle.
- R4: An accepted group raises exactly one TLB request carrying its page number. The request and page stay stable until a response arrives. No request gets ready while a translation is waiting, except in the cycle the response arrives.
- R5: The cycle after a response, the group issues for exactly one cycle. Each physical address is the response page number concatenated with the request's address bits [11:0].
- R6: Issued loads in the same line, address bits [31:6], raise one read enable: the one on the lowest load index. Each issued load's share tag holds the index of the load whose read enable serves it.
- R7: A load with a larger age than a same-cycle store to the same 8-byte word, address bits [31:3], is not accepted in that cycle. A load that is older than the store is not held back.
- R8: A request that is not accepted keeps its valid asserted and is accepted in a later cycle, including the cycle in which the previous group's response arrives.
- R9: After reset no TLB request, issue valid or read enable is asserted, and no ready is given while no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 2 | Load candidate valid, one bit per load slot |
| ld_addr | input | 64 | Load virtual addresses, slot i at bits [32i+31:32i] |
| ld_age | input | 8 | Load ages, 4 bits per slot, smaller is older |
| ld_ready | output | 2 | Load accepted this cycle |
| st_valid | input | 1 | Store candidate valid |
| st_addr | input | 32 | Store virtual address |
| st_age | input | 4 | Store age, smaller is older |
| st_ready | output | 1 | Store accepted this cycle |
| tlb_req_valid | output | 1 | Translation request outstanding |
| tlb_req_vpn | output | 20 | Virtual page number to translate |
| tlb_rsp_valid | input | 1 | Translation result valid this cycle |
| tlb_rsp_ppn | input | 20 | Physical page number |
| iss_ld_valid | output | 2 | Issued load valid per slot |
| iss_ld_paddr | output | 64 | Issued load physical addresses, slot i at bits [32i+31:32i] |
| iss_ld_tag | output | 2 | Share tag per load slot, 1 bit each |
| iss_rd_en | output | 2 | Bank read enable per load slot |
| iss_st_valid | output | 1 | Issued store valid |
| iss_st_paddr | output | 32 | Issued store physical address |

## Verification
The properties assume that the valid candidates in a cycle carry distinct ages. They also assume that a request holds its address and age until it is accepted, and that the TLB answers only while a request is outstanding. The bench gives every candidate a unique age and changes a request only after its ready. It raises the response only when it sees the TLB request, and it holds the response back for several cycles in one scenario so that the waiting rules are exercised.

// File: rtl/gm_pkg.sv
package gm_pkg;
  typedef enum logic {
    GM_IDLE = 1'b0,
    GM_WAIT = 1'b1
  } gm_state_e;
endpackage

// File: rtl/gm_select.sv
// Oldest-first page selection with a store-to-load ordering hold.
module gm_select #(
  parameter int NC      = 3,   // candidates: loads first, store last
  parameter int DW_W    = 29,  // width of the word-granular address
  parameter int AGE_W   = 4,
  parameter int VPN_LSB = 9    // page field start inside the word address
) (
  input  logic [NC-1:0]              valid,
  input  logic [NC-1:0][DW_W-1:0]    dw_addr,
  input  logic [NC-1:0][AGE_W-1:0]   age,
  output logic [NC-1:0]              pick,
  output logic [DW_W-VPN_LSB-1:0]    page
);
  localparam int ST    = NC - 1;
  localparam int IDX_W = (NC > 1) ? $clog2(NC) : 1;

  logic [IDX_W-1:0] oldest;
  logic             found;
  logic [AGE_W-1:0] best_age;
  logic [NC-1:0]    same_page;

  always_comb begin
    oldest   = '0;
    found    = 1'b0;
    best_age = '0;
    for (int i = 0; i < NC; i++) begin
      if (valid[i] && (!found || age[i] < best_age)) begin
        found    = 1'b1;
        best_age = age[i];
        oldest   = IDX_W'(i);
      end
    end
  end

  assign page = dw_addr[oldest][DW_W-1:VPN_LSB];

  genvar g;
  generate
    for (g = 0; g < NC; g++) begin : g_cand
      assign same_page[g] = valid[g] && (dw_addr[g][DW_W-1:VPN_LSB] == page);
      if (g == ST) begin : g_store
        assign pick[g] = same_page[g];
      end else begin : g_load
        logic younger_conflict;
        assign younger_conflict = same_page[ST] && (age[g] > age[ST]) &&
                                  (dw_addr[g] == dw_addr[ST]);
        assign pick[g] = same_page[g] && !younger_conflict;
      end
    end
  endgenerate
endmodule

// File: rtl/gm_merge.sv
// Same-line load merging: one read per line, share tags for followers.
module gm_merge #(
  parameter int NLD    = 2,
  parameter int LINE_W = 26,
  parameter int TAG_W  = 1
) (
  input  logic [NLD-1:0]              pick,
  input  logic [NLD-1:0][LINE_W-1:0]  line,
  output logic [NLD-1:0]              rd_en,
  output logic [NLD-1:0][TAG_W-1:0]   tag
);
  logic [NLD-1:0] joined;

  always_comb begin
    joined = '0;
    rd_en  = '0;
    tag    = '0;
    for (int i = 0; i < NLD; i++) begin
      tag[i] = TAG_W'(i);
      for (int j = 0; j < NLD; j++) begin
        if (j < i && !joined[i] && pick[j] && line[j] == line[i]) begin
          joined[i] = 1'b1;
          tag[i]    = TAG_W'(j);
        end
      end
      rd_en[i] = pick[i] && !joined[i];
    end
  end
endmodule

// File: rtl/gm_stage.sv
// Holds one admitted group across the translation and registers the issue.
module gm_stage
  import gm_pkg::*;
#(
  parameter int NLD       = 2,
  parameter int PAGE_BITS = 12,
  parameter int VPN_W     = 20,
  parameter int PPN_W     = 20,
  parameter int TAG_W     = 1,
  localparam int PA_W     = PPN_W + PAGE_BITS
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NLD:0]                    pick,
  input  logic [VPN_W-1:0]                page,
  input  logic [NLD-1:0][PAGE_BITS-1:0]   ld_off,
  input  logic [PAGE_BITS-1:0]            st_off,
  input  logic [NLD-1:0]                  rd_en,
  input  logic [NLD-1:0][TAG_W-1:0]       tag,
  input  logic                            tlb_rsp_valid,
  input  logic [PPN_W-1:0]                tlb_rsp_ppn,
  output logic                            can_take,
  output logic                            tlb_req_valid,
  output logic [VPN_W-1:0]                tlb_req_vpn,
  output logic [NLD-1:0]                  iss_ld_valid,
  output logic [NLD-1:0][PA_W-1:0]        iss_ld_paddr,
  output logic [NLD-1:0][TAG_W-1:0]       iss_ld_tag,
  output logic [NLD-1:0]                  iss_rd_en,
  output logic                            iss_st_valid,
  output logic [PA_W-1:0]                 iss_st_paddr
);
  gm_state_e                       state;
  logic [NLD-1:0]                  grp_ld_v;
  logic                            grp_st_v;
  logic [NLD-1:0][PAGE_BITS-1:0]   grp_ld_off;
  logic [PAGE_BITS-1:0]            grp_st_off;
  logic [NLD-1:0]                  grp_rd;
  logic [NLD-1:0][TAG_W-1:0]       grp_tag;
  logic                            rsp_here;
  logic                            take;

  assign rsp_here      = (state == GM_WAIT) && tlb_rsp_valid;
  assign can_take      = (state == GM_IDLE) || tlb_rsp_valid;
  assign take          = can_take && (|pick);
  assign tlb_req_valid = (state == GM_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= GM_IDLE;
      tlb_req_vpn  <= '0;
      grp_ld_v     <= '0;
      grp_st_v     <= 1'b0;
      grp_ld_off   <= '0;
      grp_st_off   <= '0;
      grp_rd       <= '0;
      grp_tag      <= '0;
      iss_ld_valid <= '0;
      iss_ld_paddr <= '0;
      iss_ld_tag   <= '0;
      iss_rd_en    <= '0;
      iss_st_valid <= 1'b0;
      iss_st_paddr <= '0;
    end else begin
      iss_ld_valid <= '0;
      iss_rd_en    <= '0;
      iss_st_valid <= 1'b0;
      if (rsp_here) begin
        iss_ld_valid <= grp_ld_v;
        iss_rd_en    <= grp_rd;
        iss_ld_tag   <= grp_tag;
        iss_st_valid <= grp_st_v;
        iss_st_paddr <= {tlb_rsp_ppn, grp_st_off};
        for (int i = 0; i < NLD; i++) begin
          iss_ld_paddr[i] <= {tlb_rsp_ppn, grp_ld_off[i]};
        end
        state <= GM_IDLE;
      end
      if (take) begin
        state       <= GM_WAIT;
        tlb_req_vpn <= page;
        grp_ld_v    <= pick[NLD-1:0];
        grp_st_v    <= pick[NLD];
        grp_ld_off  <= ld_off;
        grp_st_off  <= st_off;
        grp_rd      <= rd_en;
        grp_tag     <= tag;
      end
    end
  end
endmodule

// File: rtl/mem_access_grouper.sv
module mem_access_grouper #(
  parameter int NLD       = 2,
  parameter int ADDR_W    = 32,
  parameter int AGE_W     = 4,
  parameter int PAGE_BITS = 12,
  parameter int LINE_BITS = 6,
  parameter int WORD_BITS = 3,
  parameter int PPN_W     = 20,
  localparam int VPN_W    = ADDR_W - PAGE_BITS,
  localparam int PA_W     = PPN_W + PAGE_BITS,
  localparam int TAG_W    = (NLD > 1) ? $clog2(NLD) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NLD-1:0]          ld_valid,
  input  logic [NLD*ADDR_W-1:0]   ld_addr,
  input  logic [NLD*AGE_W-1:0]    ld_age,
  output logic [NLD-1:0]          ld_ready,
  input  logic                    st_valid,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [AGE_W-1:0]        st_age,
  output logic                    st_ready,
  output logic                    tlb_req_valid,
  output logic [VPN_W-1:0]        tlb_req_vpn,
  input  logic                    tlb_rsp_valid,
  input  logic [PPN_W-1:0]        tlb_rsp_ppn,
  output logic [NLD-1:0]          iss_ld_valid,
  output logic [NLD*PA_W-1:0]     iss_ld_paddr,
  output logic [NLD*TAG_W-1:0]    iss_ld_tag,
  output logic [NLD-1:0]          iss_rd_en,
  output logic                    iss_st_valid,
  output logic [PA_W-1:0]         iss_st_paddr
);
  localparam int NC     = NLD + 1;
  localparam int DW_W   = ADDR_W - WORD_BITS;
  localparam int LINE_W = ADDR_W - LINE_BITS;

  logic [NC-1:0]                 cand_valid;
  logic [NC-1:0][DW_W-1:0]       cand_dw;
  logic [NC-1:0][AGE_W-1:0]      cand_age;
  logic [NC-1:0]                 pick;
  logic [VPN_W-1:0]              page;
  logic [NLD-1:0][LINE_W-1:0]    ld_line;
  logic [NLD-1:0][PAGE_BITS-1:0] ld_off;
  logic [NLD-1:0]                rd_en;
  logic [NLD-1:0][TAG_W-1:0]     tag;
  logic                          can_take;
  logic [NLD-1:0][PA_W-1:0]      paddr_2d;
  logic [NLD-1:0][TAG_W-1:0]     tag_2d;

  assign cand_valid = {st_valid, ld_valid};
  assign cand_age   = {st_age, ld_age};

  genvar g;
  generate
    for (g = 0; g < NLD; g++) begin : g_ld
      assign cand_dw[g] = ld_addr[g*ADDR_W+WORD_BITS +: DW_W];
      assign ld_line[g] = ld_addr[g*ADDR_W+LINE_BITS +: LINE_W];
      assign ld_off[g]  = ld_addr[g*ADDR_W +: PAGE_BITS];
    end
  endgenerate
  assign cand_dw[NLD] = st_addr[ADDR_W-1:WORD_BITS];

  gm_select #(
    .NC(NC), .DW_W(DW_W), .AGE_W(AGE_W), .VPN_LSB(PAGE_BITS - WORD_BITS)
  ) u_select (
    .valid(cand_valid), .dw_addr(cand_dw), .age(cand_age),
    .pick(pick), .page(page)
  );

  gm_merge #(.NLD(NLD), .LINE_W(LINE_W), .TAG_W(TAG_W)) u_merge (
    .pick(pick[NLD-1:0]), .line(ld_line), .rd_en(rd_en), .tag(tag)
  );

  gm_stage #(
    .NLD(NLD), .PAGE_BITS(PAGE_BITS), .VPN_W(VPN_W), .PPN_W(PPN_W), .TAG_W(TAG_W)
  ) u_stage (
    .clk(clk), .rst(rst), .pick(pick), .page(page),
    .ld_off(ld_off), .st_off(st_addr[PAGE_BITS-1:0]),
    .rd_en(rd_en), .tag(tag),
    .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_ppn(tlb_rsp_ppn),
    .can_take(can_take),
    .tlb_req_valid(tlb_req_valid), .tlb_req_vpn(tlb_req_vpn),
    .iss_ld_valid(iss_ld_valid), .iss_ld_paddr(paddr_2d),
    .iss_ld_tag(tag_2d), .iss_rd_en(iss_rd_en),
    .iss_st_valid(iss_st_valid), .iss_st_paddr(iss_st_paddr)
  );

  assign iss_ld_paddr = paddr_2d;
  assign iss_ld_tag   = tag_2d;
  assign ld_ready     = pick[NLD-1:0] & {NLD{can_take}};
  assign st_ready     = pick[NLD] & can_take;
endmodule

// File: rtl/gm_checker.sv
module gm_checker #(
  parameter int NLD       = 2,
  parameter int ADDR_W    = 32,
  parameter int AGE_W     = 4,
  parameter int PAGE_BITS = 12,
  parameter int LINE_BITS = 6,
  parameter int WORD_BITS = 3,
  parameter int PPN_W     = 20,
  localparam int VPN_W    = ADDR_W - PAGE_BITS,
  localparam int PA_W     = PPN_W + PAGE_BITS,
  localparam int TAG_W    = (NLD > 1) ? $clog2(NLD) : 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NLD-1:0]          ld_valid,
  input logic [NLD*ADDR_W-1:0]   ld_addr,
  input logic [NLD*AGE_W-1:0]    ld_age,
  input logic [NLD-1:0]          ld_ready,
  input logic                    st_valid,
  input logic [ADDR_W-1:0]       st_addr,
  input logic [AGE_W-1:0]        st_age,
  input logic                    st_ready,
  input logic                    tlb_req_valid,
  input logic [VPN_W-1:0]        tlb_req_vpn,
  input logic                    tlb_rsp_valid,
  input logic [PPN_W-1:0]        tlb_rsp_ppn,
  input logic [NLD-1:0]          iss_ld_valid,
  input logic [NLD*PA_W-1:0]     iss_ld_paddr,
  input logic [NLD*TAG_W-1:0]    iss_ld_tag,
  input logic [NLD-1:0]          iss_rd_en,
  input logic                    iss_st_valid,
  input logic [PA_W-1:0]         iss_st_paddr
);
  logic [NLD-1:0][ADDR_W-1:0] la;
  logic [NLD-1:0][AGE_W-1:0]  lg;
  logic [NLD-1:0][PA_W-1:0]   pa;
  logic [NLD-1:0][TAG_W-1:0]  tg;
  logic                       unused_bits;

  assign la = ld_addr;
  assign lg = ld_age;
  assign pa = iss_ld_paddr;
  assign tg = iss_ld_tag;
  assign unused_bits = ^{ld_addr, st_addr[WORD_BITS-1:0], iss_st_paddr};

  AST_PROGRESS: assert property (@(posedge clk) disable iff (rst)
    ((|ld_valid) || st_valid) && (!tlb_req_valid || tlb_rsp_valid) |-> ((|ld_ready) || st_ready)); // R2
  AST_WAIT_NO_READY: assert property (@(posedge clk) disable iff (rst)
    tlb_req_valid && !tlb_rsp_valid |-> !(|ld_ready) && !st_ready); // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    tlb_req_valid && !tlb_rsp_valid |=> tlb_req_valid && $stable(tlb_req_vpn)); // R4
  AST_ISSUE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    tlb_req_valid && tlb_rsp_valid |=> (|iss_ld_valid) || iss_st_valid); // R5
  AST_ISSUE_CAUSED: assert property (@(posedge clk) disable iff (rst)
    (|iss_ld_valid) || iss_st_valid |-> $past(tlb_req_valid && tlb_rsp_valid)); // R5
  AST_ST_PAGE: assert property (@(posedge clk) disable iff (rst)
    st_ready |=> tlb_req_vpn == $past(st_addr[ADDR_W-1:PAGE_BITS])); // R1
  AST_ST_PPN: assert property (@(posedge clk) disable iff (rst)
    iss_st_valid |-> iss_st_paddr[PA_W-1:PAGE_BITS] == $past(tlb_rsp_ppn)); // R5

  genvar g, h;
  generate
    for (g = 0; g < NLD; g++) begin : g_ld
      AST_READY_VALID: assert property (@(posedge clk) disable iff (rst)
        ld_ready[g] |-> ld_valid[g]); // R1
      AST_LD_PAGE: assert property (@(posedge clk) disable iff (rst)
        ld_ready[g] |=> tlb_req_vpn == $past(la[g][ADDR_W-1:PAGE_BITS])); // R1
      AST_NO_YOUNG_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        ld_ready[g] && st_ready && (lg[g] > st_age) |->
        la[g][ADDR_W-1:WORD_BITS] != st_addr[ADDR_W-1:WORD_BITS]); // R7
      AST_LD_PPN: assert property (@(posedge clk) disable iff (rst)
        iss_ld_valid[g] |-> pa[g][PA_W-1:PAGE_BITS] == $past(tlb_rsp_ppn)); // R5
      AST_TAG_SERVED: assert property (@(posedge clk) disable iff (rst)
        iss_ld_valid[g] |-> iss_rd_en[tg[g]] &&
        pa[tg[g]][PA_W-1:LINE_BITS] == pa[g][PA_W-1:LINE_BITS]); // R6
      for (h = g + 1; h < NLD; h++) begin : g_pair
        AST_ONE_READ_PER_LINE: assert property (@(posedge clk) disable iff (rst)
          iss_rd_en[g] && iss_rd_en[h] |->
          pa[g][PA_W-1:LINE_BITS] != pa[h][PA_W-1:LINE_BITS]); // R6
      end
    end
  endgenerate
endmodule

bind mem_access_grouper gm_checker #(
  .NLD(NLD), .ADDR_W(ADDR_W), .AGE_W(AGE_W), .PAGE_BITS(PAGE_BITS),
  .LINE_BITS(LINE_BITS), .WORD_BITS(WORD_BITS), .PPN_W(PPN_W)
) u_chk (
  .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_age(ld_age),
  .ld_ready(ld_ready), .st_valid(st_valid), .st_addr(st_addr), .st_age(st_age),
  .st_ready(st_ready), .tlb_req_valid(tlb_req_valid), .tlb_req_vpn(tlb_req_vpn),
  .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_ppn(tlb_rsp_ppn),
  .iss_ld_valid(iss_ld_valid), .iss_ld_paddr(iss_ld_paddr), .iss_ld_tag(iss_ld_tag),
  .iss_rd_en(iss_rd_en), .iss_st_valid(iss_st_valid), .iss_st_paddr(iss_st_paddr)
);

// File: tb/mem_access_grouper_bench.sv
`timescale 1ns/100ps
module mem_access_grouper_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ld_valid = '0;
  logic [63:0] ld_addr = '0;
  logic [7:0]  ld_age = '0;
  logic [1:0]  ld_ready;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [3:0]  st_age = '0;
  logic        st_ready;
  logic        tlb_req_valid;
  logic [19:0] tlb_req_vpn;
  logic        tlb_rsp_valid = 1'b0;
  logic [19:0] tlb_rsp_ppn = '0;
  logic [1:0]  iss_ld_valid;
  logic [63:0] iss_ld_paddr;
  logic [1:0]  iss_ld_tag;
  logic [1:0]  iss_rd_en;
  logic        iss_st_valid;
  logic [31:0] iss_st_paddr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [19:0] PG_A = 20'h12345;
  localparam logic [19:0] PG_B = 20'h0ABCD;

  always #2.5 clk = ~clk;

  mem_access_grouper u_mem_access_grouper (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_age(ld_age),
    .ld_ready(ld_ready), .st_valid(st_valid), .st_addr(st_addr), .st_age(st_age),
    .st_ready(st_ready), .tlb_req_valid(tlb_req_valid), .tlb_req_vpn(tlb_req_vpn),
    .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_ppn(tlb_rsp_ppn),
    .iss_ld_valid(iss_ld_valid), .iss_ld_paddr(iss_ld_paddr), .iss_ld_tag(iss_ld_tag),
    .iss_rd_en(iss_rd_en), .iss_st_valid(iss_st_valid), .iss_st_paddr(iss_st_paddr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_ld(input int i, input logic [31:0] a, input logic [3:0] ag);
    ld_valid[i]        = 1'b1;
    ld_addr[i*32 +: 32] = a;
    ld_age[i*4 +: 4]    = ag;
  endtask

  task automatic set_st(input logic [31:0] a, input logic [3:0] ag);
    st_valid = 1'b1;
    st_addr  = a;
    st_age   = ag;
  endtask

  // respond to the pending translation and move to the issue cycle
  task automatic respond(input logic [19:0] ppn);
    tlb_rsp_valid = 1'b1;
    tlb_rsp_ppn   = ppn;
    step();
    tlb_rsp_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 tlb_req_valid", 64'(tlb_req_valid), 0);
    chk("R9 iss_ld_valid", 64'(iss_ld_valid), 0);
    chk("R9 iss_rd_en", 64'(iss_rd_en), 0);
    chk("R9 iss_st_valid", 64'(iss_st_valid), 0);
    chk("R9 ready idle", 64'({ld_ready, st_ready}), 0);
  endtask

  task automatic t_full_group();
    set_ld(0, {PG_A, 12'h040}, 4'd1);
    set_ld(1, {PG_A, 12'h080}, 4'd2);
    set_st({PG_A, 12'h100}, 4'd0);
    #1;
    chk("R3 ld_ready", 64'(ld_ready), 64'h3);
    chk("R3 st_ready", 64'(st_ready), 1);
    step();
    ld_valid = '0; st_valid = 1'b0;
    chk("R4 tlb_req_valid", 64'(tlb_req_valid), 1);
    chk("R1 tlb_req_vpn", 64'(tlb_req_vpn), 64'(PG_A));
    respond(20'h55555);
    chk("R5 iss_ld_valid", 64'(iss_ld_valid), 64'h3);
    chk("R5 ld0 paddr", 64'(iss_ld_paddr[31:0]), 64'h55555040);
    chk("R5 ld1 paddr", 64'(iss_ld_paddr[63:32]), 64'h55555080);
    chk("R5 st paddr", 64'({iss_st_valid, iss_st_paddr}), 64'h1_55555100);
    chk("R6 rd_en distinct lines", 64'(iss_rd_en), 64'h3);
    chk("R6 tags distinct lines", 64'(iss_ld_tag), 64'h2);
    step();
    chk("R5 issue one cycle", 64'({iss_ld_valid, iss_st_valid}), 0);
    chk("R4 request done", 64'(tlb_req_valid), 0);
  endtask

  task automatic t_merge();
    set_ld(0, {PG_A, 12'h048}, 4'd3);
    set_ld(1, {PG_A, 12'h070}, 4'd2);
    #1;
    chk("R6 both loads ready", 64'(ld_ready), 64'h3);
    step();
    ld_valid = '0;
    respond(20'h0F0F0);
    chk("R6 merged rd_en", 64'(iss_rd_en), 64'h1);
    chk("R6 merged tags", 64'(iss_ld_tag), 64'h0);
    chk("R5 merged ld1 paddr", 64'(iss_ld_paddr[63:32]), 64'h0F0F0070);
    step();
  endtask

  task automatic t_page_split();
    set_ld(0, {PG_B, 12'h010}, 4'd5);
    set_ld(1, {PG_A, 12'h3C0}, 4'd2);
    set_st({PG_A, 12'h400}, 4'd4);
    #1;
    chk("R1 other page not ready", 64'(ld_ready), 64'h2);
    chk("R2 oldest page store ready", 64'(st_ready), 1);
    step();
    ld_valid[1] = 1'b0; st_valid = 1'b0;
    chk("R1 vpn of oldest", 64'(tlb_req_vpn), 64'(PG_A));
    tlb_rsp_valid = 1'b1;
    tlb_rsp_ppn   = 20'h11111;
    #1;
    chk("R8 retry accepted at response", 64'(ld_ready), 64'h1);
    step();
    tlb_rsp_valid = 1'b0;
    ld_valid = '0;
    chk("R5 first group loads", 64'(iss_ld_valid), 64'h2);
    chk("R5 first group ld1", 64'(iss_ld_paddr[63:32]), 64'h111113C0);
    chk("R5 first group st", 64'({iss_st_valid, iss_st_paddr}), 64'h1_11111400);
    chk("R8 retried page", 64'(tlb_req_vpn), 64'(PG_B));
    respond(20'h22222);
    chk("R8 retried load issued", 64'(iss_ld_valid), 64'h1);
    chk("R8 retried ld0 paddr", 64'(iss_ld_paddr[31:0]), 64'h22222010);
    chk("R6 single load rd", 64'(iss_rd_en), 64'h1);
    step();
  endtask

  task automatic t_hazard();
    set_st({PG_A, 12'h200}, 4'd1);
    set_ld(0, {PG_A, 12'h204}, 4'd2);
    set_ld(1, {PG_A, 12'h208}, 4'd3);
    #1;
    chk("R7 younger overlap held", 64'(ld_ready), 64'h2);
    chk("R7 store ready", 64'(st_ready), 1);
    step();
    ld_valid[1] = 1'b0; st_valid = 1'b0;
    respond(20'h44444);
    chk("R7 group without held load", 64'({iss_ld_valid, iss_st_valid}), 64'h5);
    chk("R8 held load pending", 64'(tlb_req_valid), 1);
    chk("R8 held load page", 64'(tlb_req_vpn), 64'(PG_A));
    ld_valid = '0;
    respond(20'h44444);
    chk("R8 held load issued", 64'(iss_ld_paddr[31:0]), 64'h44444204);
    chk("R8 held load valid", 64'(iss_ld_valid), 64'h1);
    step();
    // an older load to the same word is not held back
    set_ld(0, {PG_A, 12'h300}, 4'd0);
    set_st({PG_A, 12'h300}, 4'd1);
    #1;
    chk("R7 older overlap allowed", 64'({ld_ready, st_ready}), 64'h3);
    step();
    ld_valid = '0; st_valid = 1'b0;
    respond(20'h66666);
    step();
  endtask

  task automatic t_stall();
    set_ld(0, {PG_A, 12'h000}, 4'd1);
    step();
    ld_valid = '0;
    set_ld(1, {PG_B, 12'h0C0}, 4'd2);
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R4 no ready while waiting", 64'({ld_ready, st_ready}), 0);
      chk("R4 vpn held", 64'({tlb_req_valid, tlb_req_vpn}), {43'd0, 1'b1, PG_A});
      chk("R5 no issue before response", 64'(iss_ld_valid), 0);
      step();
    end
    tlb_rsp_valid = 1'b1;
    tlb_rsp_ppn   = 20'h33333;
    #1;
    chk("R4 accept at response", 64'(ld_ready), 64'h2);
    step();
    tlb_rsp_valid = 1'b0;
    ld_valid = '0;
    chk("R5 stalled group issue", 64'({iss_ld_valid, iss_ld_paddr[31:0]}), {30'd0, 2'b01, 32'h33333000});
    chk("R4 next page requested", 64'(tlb_req_vpn), 64'(PG_B));
    respond(20'h77777);
    chk("R6 slot1 leader", 64'({iss_rd_en, iss_ld_tag[1]}), 64'b101);
    chk("R5 slot1 paddr", 64'(iss_ld_paddr[63:32]), 64'h777770C0);
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step();
    t_reset();
    t_full_group();
    t_merge();
    t_page_split();
    t_hazard();
    t_stall();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule